// File: doc/BRIEF.md
# Region Eviction Drain Buffer

This block sits beside a cache's region tag array and takes in whole region entries that the array has displaced. Each stored entry keeps the region tag and, for every block of the region, a present flag and the cache way that block occupies. It stores no cache data. When a region is replaced, its resident blocks do not all have to leave the data array in the same cycle. The buffer holds the region and sends those blocks to the data array's eviction path one per handshake, in the background.

Draining is eager. The entry that arrived first is always the one being drained, and an entry stops being occupied as soon as its last present block has been acknowledged. A combinational lookup port lets the cache find a region that is waiting in the buffer, and returns the way of a requested block that has not yet been evicted. When every slot is occupied, the block raises a stall toward the cache. Any insert offered during a stall is dropped.

Top module: `region_evict_buffer`

## Requirements
- R1: After reset the buffer is empty: `stall` is 0, `ev_req` is 0, and every lookup returns `lk_hit` = 0.
- R2: An insert (`ins_valid` = 1) with at least one bit of `ins_present` set takes one free slot. An insert whose `ins_present` is all zero is ignored, so its tag never hits and occupancy does not change.
- R3: The buffer holds ENTRIES (default 12) regions. `stall` is 1 exactly when all slots are occupied.
- R4: An insert offered while `stall` is 1 is ignored. Its tag never hits, and it is never drained.
- R5: The eviction port always serves the oldest occupied entry, by insertion order. Within that entry it picks the present block with the lowest index, and it drives that entry's tag on `ev_tag`, the block index on `ev_blk` and the block's stored way on `ev_way`.
- R6: While `ev_req` is 1 and `ev_ack` is 0, `ev_req`, `ev_tag`, `ev_blk` and `ev_way` hold their values into the next cycle.
- R7: An edge with `ev_req` and `ev_ack` both 1 clears that block's present flag. If that was the last present flag of the entry, the entry is freed on the same edge, and the request moves on to the next oldest entry. Once the buffer is empty, `ev_req` is 0.
- R8: When an entry is freed while the buffer is full and nothing is inserted on that edge, `stall` is 0 in the following cycle.
- R9: The lookup is combinational. `lk_hit` is 1 when `lk_tag` matches an occupied entry. `lk_present` is 1 when, in addition, block `lk_blk` of that entry is still present, and `lk_way` then gives its way. Otherwise `lk_way` is 0.
- R10: When the buffer is not full, an insert and an eviction acknowledge on the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Displaced region offered for insertion |
| ins_tag | input | TAG_W | Tag of the displaced region |
| ins_present | input | BLKS | Per-block present flags, bit i for block i |
| ins_way | input | BLKS*WAY_W | Way of block i in bits [i*WAY_W +: WAY_W] |
| lk_tag | input | TAG_W | Region tag to look up |
| lk_blk | input | $clog2(BLKS) | Block index within the looked-up region |
| lk_hit | output | 1 | Region is held in the buffer |
| lk_present | output | 1 | Requested block is still waiting for eviction |
| lk_way | output | WAY_W | Way of the requested block, 0 when not present |
| ev_req | output | 1 | Block eviction request to the data array |
| ev_tag | output | TAG_W | Region tag of the requested block |
| ev_blk | output | $clog2(BLKS) | Block index within the region |
| ev_way | output | WAY_W | Way holding the block |
| ev_ack | input | 1 | Data array accepts the current request |
| stall | output | 1 | Back-pressure: all slots occupied |

## Verification
The drain path is run with one region per slot, and each region gets a different present pattern: a single top block, all sixteen blocks, and scattered mixes. A wrong within-entry order or a wrong way lookup therefore shows up as a mismatched block index or way. An acknowledge pattern with gaps separates holding a request from advancing it. An insert made during a drain that is still under way separates correct same-edge handling from lost updates. Lookups cover every block of every resident region, and then the blocks that have already been drained, which tells a stale present flag apart from a freed region. A zero-present insert and an insert made while full both need to leave no trace in lookups, in the drain order or in the stall timing.

// File: rtl/reb_pkg.sv
package reb_pkg;

   // Next position on a ring of the given depth.
   function automatic int unsigned wrap_next(int unsigned pos, int unsigned depth);
      return (pos + 1 >= depth) ? 0 : pos + 1;
   endfunction

endpackage

// File: rtl/reb_pick_low.sv
module reb_pick_low #(
   parameter int W = 16,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);

   always_comb begin
      found = |vec;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/reb_match.sv
module reb_match #(
   parameter int N    = 12,
   parameter int TW   = 40,
   localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  valid,
   input  logic [TW-1:0] tags [N],
   input  logic [TW-1:0] key,
   output logic          hit,
   output logic [IW-1:0] idx
);

   logic [N-1:0] eq_vec;

   for (genvar k = 0; k < N; k++) begin : g_cmp
      assign eq_vec[k] = valid[k] && (tags[k] == key);
   end

   reb_pick_low #(.W(N)) u_first (
      .vec   (eq_vec),
      .found (hit),
      .idx   (idx)
   );

endmodule

// File: rtl/reb_ring.sv
module reb_ring #(
   parameter int DEPTH = 12,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   output logic [PW-1:0] head,
   output logic [PW-1:0] tail,
   output logic [CW-1:0] count,
   output logic          full
);

   logic [PW-1:0] head_q, tail_q, head_nx, tail_nx;
   logic [CW-1:0] count_q;

   if ((1 << PW) == DEPTH) begin : g_pow2
      assign head_nx = head_q + 1'b1;
      assign tail_nx = tail_q + 1'b1;
   end else begin : g_wrap
      assign head_nx = PW'(reb_pkg::wrap_next(int'(head_q), DEPTH));
      assign tail_nx = PW'(reb_pkg::wrap_next(int'(tail_q), DEPTH));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         if (pop)  head_q <= head_nx;
         if (push) tail_q <= tail_nx;
         count_q <= count_q + CW'(push) - CW'(pop);
      end
   end

   assign head  = head_q;
   assign tail  = tail_q;
   assign count = count_q;
   assign full  = (count_q == CW'(DEPTH));

endmodule

// File: rtl/region_evict_buffer.sv
module region_evict_buffer #(
   parameter int ENTRIES = 12,
   parameter int TAG_W   = 40,
   parameter int BLKS    = 16,
   parameter int WAY_W   = 4,
   localparam int BLK_W  = $clog2(BLKS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ins_valid,
   input  logic [TAG_W-1:0]      ins_tag,
   input  logic [BLKS-1:0]       ins_present,
   input  logic [BLKS*WAY_W-1:0] ins_way,
   input  logic [TAG_W-1:0]      lk_tag,
   input  logic [BLK_W-1:0]      lk_blk,
   output logic                  lk_hit,
   output logic                  lk_present,
   output logic [WAY_W-1:0]      lk_way,
   output logic                  ev_req,
   output logic [TAG_W-1:0]      ev_tag,
   output logic [BLK_W-1:0]      ev_blk,
   output logic [WAY_W-1:0]      ev_way,
   input  logic                  ev_ack,
   output logic                  stall
);

   localparam int PTR_W = $clog2(ENTRIES);
   localparam int CNT_W = $clog2(ENTRIES + 1);

   if (ENTRIES < 3) begin : g_bad_depth
      $error("region_evict_buffer: ENTRIES must be at least 3");
   end
   if (BLKS < 2 || (1 << BLK_W) != BLKS) begin : g_bad_blks
      $error("region_evict_buffer: BLKS must be a power of two, at least 2");
   end
   if (TAG_W < 1 || WAY_W < 1) begin : g_bad_width
      $error("region_evict_buffer: TAG_W and WAY_W must be positive");
   end

   logic [PTR_W-1:0]      head_ptr, tail_ptr;
   logic [CNT_W-1:0]      occ_cnt;
   logic                  is_full;
   logic                  push, pop, take;
   logic [ENTRIES-1:0]    occ_vec;
   logic [TAG_W-1:0]      tag_a  [ENTRIES];
   logic [BLKS-1:0]       pres_a [ENTRIES];
   logic [BLKS*WAY_W-1:0] way_a  [ENTRIES];
   logic [BLKS-1:0]       hd_pres, clr_mask;
   logic                  drn_found;
   logic [BLK_W-1:0]      drn_blk;
   logic [PTR_W-1:0]      lk_idx;

   // Ordering: slots are filled and freed in ring order, so the head is the oldest.
   reb_ring #(.DEPTH(ENTRIES)) u_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .head  (head_ptr),
      .tail  (tail_ptr),
      .count (occ_cnt),
      .full  (is_full)
   );

   assign stall = is_full;
   assign push  = ins_valid && (|ins_present) && !is_full;

   // Drain selection: lowest present block of the head entry.
   assign hd_pres = pres_a[head_ptr];

   reb_pick_low #(.W(BLKS)) u_drain_pick (
      .vec   (hd_pres),
      .found (drn_found),
      .idx   (drn_blk)
   );

   assign ev_req   = occ_vec[head_ptr] && drn_found;
   assign ev_tag   = tag_a[head_ptr];
   assign ev_blk   = drn_blk;
   assign ev_way   = way_a[head_ptr][drn_blk*WAY_W +: WAY_W];
   assign take     = ev_req && ev_ack;
   assign clr_mask = BLKS'(1) << drn_blk;
   assign pop      = take && ((hd_pres & ~clr_mask) == '0);

   // Per-slot storage.
   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic                  occ_r;
      logic [BLKS-1:0]       pres_r;
      logic [TAG_W-1:0]      tag_r;
      logic [BLKS*WAY_W-1:0] way_r;
      logic                  at_head, at_tail;

      assign at_head = (head_ptr == PTR_W'(e));
      assign at_tail = (tail_ptr == PTR_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            occ_r  <= 1'b0;
            pres_r <= '0;
         end else begin
            if (take && at_head) begin
               pres_r <= pres_r & ~clr_mask;
               if (pop) occ_r <= 1'b0;
            end
            if (push && at_tail) begin
               occ_r  <= 1'b1;
               pres_r <= ins_present;
            end
         end
      end

      always_ff @(posedge clk) begin
         if (push && at_tail) begin
            tag_r <= ins_tag;
            way_r <= ins_way;
         end
      end

      assign occ_vec[e] = occ_r;
      assign tag_a[e]   = tag_r;
      assign pres_a[e]  = pres_r;
      assign way_a[e]   = way_r;
   end

   // Associative lookup over all occupied slots.
   reb_match #(.N(ENTRIES), .TW(TAG_W)) u_lookup (
      .valid (occ_vec),
      .tags  (tag_a),
      .key   (lk_tag),
      .hit   (lk_hit),
      .idx   (lk_idx)
   );

   assign lk_present = lk_hit && pres_a[lk_idx][lk_blk];
   assign lk_way     = lk_present ? way_a[lk_idx][lk_blk*WAY_W +: WAY_W] : '0;

endmodule

// File: rtl/reb_checker.sv
module reb_checker #(
   parameter int ENTRIES = 12,
   parameter int TAG_W   = 40,
   parameter int BLKS    = 16,
   parameter int WAY_W   = 4,
   localparam int BLK_W  = $clog2(BLKS),
   localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ins_valid,
   input logic [BLKS-1:0]  ins_present,
   input logic             ev_req,
   input logic             ev_ack,
   input logic [TAG_W-1:0] ev_tag,
   input logic [BLK_W-1:0] ev_blk,
   input logic [WAY_W-1:0] ev_way,
   input logic             stall,
   input logic [CNT_W-1:0] cnt
);

   p_idle_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_req |-> cnt == '0);

   p_zero_ins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid && ins_present == '0 && !ev_ack |=> $stable(cnt));

   p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(ENTRIES));

   p_full_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> ev_req);

   p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stall && !ev_ack |=> stall && $stable(cnt));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_req && !ev_ack |=> ev_req && $stable(ev_tag) && $stable(ev_blk) && $stable(ev_way));

   p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall) |-> $past(ev_req && ev_ack));

endmodule

bind region_evict_buffer reb_checker #(
   .ENTRIES (ENTRIES),
   .TAG_W   (TAG_W),
   .BLKS    (BLKS),
   .WAY_W   (WAY_W)
) u_reb_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ins_valid   (ins_valid),
   .ins_present (ins_present),
   .ev_req      (ev_req),
   .ev_ack      (ev_ack),
   .ev_tag      (ev_tag),
   .ev_blk      (ev_blk),
   .ev_way      (ev_way),
   .stall       (stall),
   .cnt         (occ_cnt)
);

// File: tb/tb_region_evict_buffer.sv
`timescale 1ns/100ps
module tb_region_evict_buffer;

   localparam int ENTRIES = 12;
   localparam int TAG_W   = 40;
   localparam int BLKS    = 16;
   localparam int WAY_W   = 4;
   localparam int BLK_W   = 4;

   logic                  clk = 1'b0;
   logic                  rst_n;
   logic                  ins_valid;
   logic [TAG_W-1:0]      ins_tag;
   logic [BLKS-1:0]       ins_present;
   logic [BLKS*WAY_W-1:0] ins_way;
   logic [TAG_W-1:0]      lk_tag;
   logic [BLK_W-1:0]      lk_blk;
   logic                  lk_hit, lk_present;
   logic [WAY_W-1:0]      lk_way;
   logic                  ev_req;
   logic [TAG_W-1:0]      ev_tag;
   logic [BLK_W-1:0]      ev_blk;
   logic [WAY_W-1:0]      ev_way;
   logic                  ev_ack;
   logic                  stall;

   always #10 clk = ~clk;

   region_evict_buffer #(
      .ENTRIES (ENTRIES), .TAG_W (TAG_W), .BLKS (BLKS), .WAY_W (WAY_W)
   ) dut (
      .clk (clk), .rst_n (rst_n),
      .ins_valid (ins_valid), .ins_tag (ins_tag), .ins_present (ins_present), .ins_way (ins_way),
      .lk_tag (lk_tag), .lk_blk (lk_blk), .lk_hit (lk_hit), .lk_present (lk_present), .lk_way (lk_way),
      .ev_req (ev_req), .ev_tag (ev_tag), .ev_blk (ev_blk), .ev_way (ev_way), .ev_ack (ev_ack),
      .stall (stall)
   );

   int checks = 0;
   int errors = 0;

   // Reference queue: linear, never wraps in this run.
   logic [TAG_W-1:0] m_tag  [32];
   logic [BLKS-1:0]  m_mask [32];
   logic [WAY_W-1:0] m_way  [32][BLKS];
   int qh = 0;
   int qt = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [BLKS-1:0] gen_mask(input int i);
      if (i == 3) return 16'h8000;
      if (i == 5) return 16'hFFFF;
      return 16'((i * 16'h2F1B + 16'h0421) ^ (i << 9)) | 16'(1 << (i % 16));
   endfunction

   function automatic logic [WAY_W-1:0] gen_way(input int i, input int b);
      return 4'((i * 3 + b * 5) % 16);
   endfunction

   function automatic int low_bit(input logic [BLKS-1:0] m);
      for (int b = 0; b < BLKS; b++) if (m[b]) return b;
      return -1;
   endfunction

   task automatic set_insert(input logic [TAG_W-1:0] t, input logic [BLKS-1:0] m, input int i);
      ins_valid   = 1'b1;
      ins_tag     = t;
      ins_present = m;
      for (int b = 0; b < BLKS; b++) ins_way[b*WAY_W +: WAY_W] = gen_way(i, b);
   endtask

   task automatic model_push(input logic [TAG_W-1:0] t, input logic [BLKS-1:0] m, input int i);
      m_tag[qt]  = t;
      m_mask[qt] = m;
      for (int b = 0; b < BLKS; b++) m_way[qt][b] = gen_way(i, b);
      qt++;
   endtask

   task automatic probe(input logic [TAG_W-1:0] t, input int b, input bit e_hit,
                        input bit e_pres, input logic [WAY_W-1:0] e_way, input string req);
      lk_tag = t;
      lk_blk = BLK_W'(b);
      #1;
      chk(lk_hit == e_hit, req, "lk_hit", lk_hit, e_hit);
      chk(lk_present == e_pres, req, "lk_present", lk_present, e_pres);
      chk(lk_way == e_way, req, "lk_way", lk_way, e_way);
   endtask

   initial begin
      #(200000 * 20);
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; ins_valid = 1'b0; ins_tag = '0; ins_present = '0; ins_way = '0;
      lk_tag = '0; lk_blk = '0; ev_ack = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: empty after reset
      chk(stall == 1'b0, "R1", "stall", stall, 0);
      chk(ev_req == 1'b0, "R1", "ev_req", ev_req, 0);
      probe(40'h100, 0, 0, 0, 0, "R1");

      // Fill all slots; one zero-present insert in the middle (R2).
      for (int i = 0; i < ENTRIES; i++) begin
         if (i == 6) begin
            @(negedge clk);
            set_insert(40'h66, '0, 6);
            #1;
         end
         @(negedge clk);
         chk(stall == 1'b0, "R3", "stall while filling", stall, 0);
         set_insert(40'h100 + TAG_W'(i), gen_mask(i), i);
         model_push(40'h100 + TAG_W'(i), gen_mask(i), i);
      end
      @(negedge clk);
      ins_valid = 1'b0;
      #1;
      chk(stall == 1'b1, "R3", "stall when full", stall, 1);
      chk(ev_req == 1'b1, "R5", "ev_req when full", ev_req, 1);

      // R4: insert while full is dropped.
      set_insert(40'h777, 16'h0F0F, 13);
      @(negedge clk);
      ins_valid = 1'b0;
      #1;
      chk(stall == 1'b1, "R4", "stall after rejected insert", stall, 1);

      // R9: exhaustive lookup over resident regions; misses for dropped inserts.
      for (int k = 0; k < ENTRIES; k++) begin
         for (int b = 0; b < BLKS; b++) begin
            @(negedge clk);
            probe(m_tag[k], b, 1, m_mask[k][b], m_mask[k][b] ? m_way[k][b] : '0, "R9");
         end
      end
      @(negedge clk);
      probe(40'h777, 0, 0, 0, 0, "R4");
      probe(40'h66, 0, 0, 0, 0, "R2");

      // Drain with gaps in the acknowledge; one insert mid-drain (R10).
      begin
         int cyc = 0;
         bit inserted = 0;
         int last_k = -1;
         int last_b = -1;
         bit prev_hold = 0;
         logic [TAG_W-1:0] prev_tag = '0;
         logic [BLK_W-1:0] prev_blk = '0;
         while (qh != qt && cyc < 4000) begin
            int b;
            bit ack;
            @(negedge clk);
            ins_valid = 1'b0;
            ev_ack = 1'b0;
            #1;
            chk(stall == ((qt - qh) == ENTRIES), "R8", "stall vs occupancy", stall, (qt - qh) == ENTRIES);
            chk(ev_req == 1'b1, "R7", "ev_req while occupied", ev_req, 1);
            b = low_bit(m_mask[qh]);
            chk(ev_tag == m_tag[qh], "R5", "ev_tag", ev_tag, m_tag[qh]);
            chk(int'(ev_blk) == b, "R5", "ev_blk", ev_blk, b);
            chk(ev_way == m_way[qh][b], "R5", "ev_way", ev_way, m_way[qh][b]);
            if (prev_hold) begin
               chk(ev_tag == prev_tag, "R6", "held ev_tag", ev_tag, prev_tag);
               chk(ev_blk == prev_blk, "R6", "held ev_blk", ev_blk, prev_blk);
            end
            if (last_k >= 0) probe(m_tag[last_k], last_b, last_k >= qh, 0, 0, "R7");
            ack = (cyc % 3) != 1;
            if (!inserted && (qt - qh) < ENTRIES) begin
               set_insert(40'h500, gen_mask(12), 12);
               model_push(40'h500, gen_mask(12), 12);
               inserted = 1;
               ack = 1;
            end
            ev_ack = ack;
            prev_hold = !ack;
            prev_tag = ev_tag;
            prev_blk = ev_blk;
            if (ack) begin
               m_mask[qh][b] = 1'b0;
               last_k = qh;
               last_b = b;
               if (m_mask[qh] == '0) qh++;
            end
            cyc++;
         end
         chk(inserted == 1'b1, "R10", "mid-drain insert offered", inserted, 1);
      end
      @(negedge clk);
      ins_valid = 1'b0;
      ev_ack = 1'b0;
      #1;
      chk(ev_req == 1'b0, "R7", "ev_req when drained", ev_req, 0);
      chk(stall == 1'b0, "R8", "stall when drained", stall, 0);
      chk(qt == ENTRIES + 1, "R10", "regions drained", qt, ENTRIES + 1);
      probe(40'h500, 1, 0, 0, 0, "R7");
      probe(40'h777, 0, 0, 0, 0, "R4");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule